// File: doc/BRIEF.md
# Shared-Memory Inter-Processor Ring Queue Controller

This block runs one direction of a message queue between two processors. The queue lives in a word-addressed shared memory, which is modelled here as an internal array. The window occupied by the queue is set at run time by a lower and an upper bound address. The block keeps a write pointer and a read pointer inside that window. Both pointers step from the upper bound back to the lower bound.

Several producer requesters share one write port. A round-robin arbiter accepts one message of one to three words at a time. It checks for room before granting, and rejects the message if the window has too little room. While granted, the owner streams the words into the memory. The message stays invisible to the consumer until the last word is stored. At that point the write pointer jumps forward by the whole message and a single-cycle interrupt tells the consumer that new data is waiting.

The consumer sees the word at the read pointer at all times and can inspect it without removing it. A separate pop strobe removes the word. A pop while the queue is empty changes nothing and raises a sticky underflow flag. The queue always keeps one word unused, so equal pointers can only mean that the queue is empty.

Top module: `ipc_ring_queue`

## Requirements
- R1: After reset, the bounds and both pointers are 0, the queue reports empty and not ready, no grant, reject or done is active, and irq_msg and cons_underflow are low.
- R2: A cycle with cfg_we high loads q_lo and q_hi from cfg_lo and cfg_hi, sets both pointers to cfg_lo and clears cons_underflow, all from the next cycle. q_ready is 1 exactly when q_lo <= q_hi and the window holds at least 3 words (q_hi - q_lo + 1 >= 3).
- R3: q_free equals (q_rptr - q_wptr - 1) modulo the window size while ready, and 0 otherwise. A request is granted only if its length field is 1, 2 or 3 and is no larger than q_free. A length of 0, or a length above q_free, gives a one-cycle pulse on that requester's prod_rej bit, and the pointers and queue contents stay unchanged.
- R4: A pointer that advances from q_hi takes the value q_lo. Both pointers always stay within [q_lo, q_hi] while ready.
- R5: q_wptr stays unchanged while message words are being written. It advances by the message length in the cycle after the last word is accepted. In that same cycle, irq_msg and the owner's prod_done bit are high for exactly one cycle.
- R6: At most one prod_gnt bit is high at a time. A grant stays high from its first cycle until its done cycle. Among simultaneous requests, the arbiter starts searching at the index after the last requester served or rejected, and right after reset requester 0 has priority.
- R7: cons_rdata always shows the word at q_rptr. It is not consumed unless cons_pop is high. A pop on a non-empty queue advances q_rptr by one word in the next cycle.
- R8: A pop while cons_empty is high leaves q_rptr unchanged and sets cons_underflow. cons_underflow stays set until the next configuration write.
- R9: cons_empty is 1 exactly when q_rptr equals q_wptr.
- R10: While q_ready is 0, every request is rejected with a prod_rej pulse and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load new window bounds and reset both pointers |
| cfg_lo | input | AW | New lower bound address |
| cfg_hi | input | AW | New upper bound address |
| prod_req | input | NREQ | Request bit, one per producer |
| prod_len | input | 2*NREQ | Message length (1..3), two bits per producer, producer i at bits [2i+1:2i] |
| prod_wvalid | input | NREQ | Word valid from each producer while it is granted |
| prod_wdata | input | DW*NREQ | Word data, producer i at bits [DW*i+DW-1:DW*i] |
| prod_gnt | output | NREQ | One-hot grant, held for the whole transfer |
| prod_rej | output | NREQ | One-cycle pulse: request refused |
| prod_done | output | NREQ | One-cycle pulse: message committed |
| cons_pop | input | 1 | Remove the word at the read pointer |
| cons_rdata | output | DW | Word at the read pointer |
| cons_empty | output | 1 | The two pointers are equal |
| cons_underflow | output | 1 | Sticky flag: a pop was attempted on an empty queue |
| irq_msg | output | 1 | One-cycle pulse to the consumer on each commit |
| q_lo | output | AW | Current lower bound |
| q_hi | output | AW | Current upper bound |
| q_wptr | output | AW | Committed write pointer |
| q_rptr | output | AW | Read pointer |
| q_free | output | AW+1 | Free words under the one-slot-unused rule |
| q_ready | output | 1 | The current bounds form a usable window |

## Verification
Several properties are checked on every cycle. The grant is one-hot or idle and is held until its done pulse. The write pointer moves only together with the interrupt. The interrupt lasts one cycle and never leaves the queue empty. The pointers stay inside the window and the free count stays below the window size. A pop on an empty queue only sets the flag, and no grant is given while the window is invalid. The bench scenarios cover what those properties cannot: the exact free-space arithmetic and the accept/reject choice at the limit, the stored words coming back in order across a wrap, round-robin order under contention, and the effect of a configuration write.

// File: rtl/ipcq_pkg.sv
package ipcq_pkg;

    // Arbiter / write-port sequencing
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_XFER = 2'd1,
        ARB_HOLD = 2'd2
    } arb_state_e;

    localparam int unsigned LEN_W        = 2;
    localparam int unsigned MIN_WIN_WORDS = 3;

endpackage

// File: rtl/ipcq_mem.sv
module ipcq_mem #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/ipcq_window.sv
module ipcq_window #(
    parameter int unsigned AW    = 6,
    parameter int unsigned NSTEP = 2
) (
    input  logic [AW-1:0]       win_lo,
    input  logic [AW-1:0]       win_hi,
    input  logic [AW-1:0]       wr_ptr,
    input  logic [AW-1:0]       rd_ptr,
    input  logic [NSTEP*AW-1:0] step_in,
    output logic [NSTEP*AW-1:0] step_out,
    output logic [AW:0]         win_size,
    output logic [AW:0]         free_cnt,
    output logic                win_ok,
    output logic                is_empty
);
    import ipcq_pkg::*;

    localparam int unsigned CW = AW + 1;

    logic [CW-1:0] lo_x, hi_x, wr_x, rd_x;

    assign lo_x = {1'b0, win_lo};
    assign hi_x = {1'b0, win_hi};
    assign wr_x = {1'b0, wr_ptr};
    assign rd_x = {1'b0, rd_ptr};

    always_comb begin
        win_size = hi_x - lo_x + CW'(1);
        win_ok   = (win_hi >= win_lo) && (win_size >= CW'(MIN_WIN_WORDS));
        is_empty = (wr_ptr == rd_ptr);
        if (!win_ok) begin
            free_cnt = '0;
        end else if (rd_x > wr_x) begin
            free_cnt = rd_x - wr_x - CW'(1);
        end else begin
            free_cnt = win_size - (wr_x - rd_x) - CW'(1);
        end
    end

    // One circular increment per pointer that needs it
    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        logic [AW-1:0] cur;
        assign cur = step_in[g*AW +: AW];
        assign step_out[g*AW +: AW] = (cur == win_hi) ? win_lo : cur + AW'(1);
    end

endmodule

// File: rtl/ipcq_rr_arb.sv
module ipcq_rr_arb #(
    parameter int unsigned NREQ = 2,
    parameter int unsigned IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] req,
    input  logic [IW-1:0]   last,
    output logic            any,
    output logic [IW-1:0]   pick
);
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = '0;
        idx  = 0;
        for (int k = 1; k <= int'(NREQ); k++) begin
            idx = (int'(last) + k) % int'(NREQ);
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/ipc_ring_queue.sv
module ipc_ring_queue #(
    parameter int unsigned AW   = 6,
    parameter int unsigned DW   = 32,
    parameter int unsigned NREQ = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_lo,
    input  logic [AW-1:0]     cfg_hi,
    input  logic [NREQ-1:0]   prod_req,
    input  logic [2*NREQ-1:0] prod_len,
    input  logic [NREQ-1:0]   prod_wvalid,
    input  logic [DW*NREQ-1:0] prod_wdata,
    output logic [NREQ-1:0]   prod_gnt,
    output logic [NREQ-1:0]   prod_rej,
    output logic [NREQ-1:0]   prod_done,
    input  logic              cons_pop,
    output logic [DW-1:0]     cons_rdata,
    output logic              cons_empty,
    output logic              cons_underflow,
    output logic              irq_msg,
    output logic [AW-1:0]     q_lo,
    output logic [AW-1:0]     q_hi,
    output logic [AW-1:0]     q_wptr,
    output logic [AW-1:0]     q_rptr,
    output logic [AW:0]       q_free,
    output logic              q_ready
);
    import ipcq_pkg::*;

    localparam int unsigned IW = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        arb_state_e      st;
        logic [AW-1:0]   lo;
        logic [AW-1:0]   hi;
        logic [AW-1:0]   wptr;
        logic [AW-1:0]   rptr;
        logic [AW-1:0]   shadow;
        logic [IW-1:0]   owner;
        logic [IW-1:0]   last;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [NREQ-1:0] rej;
        logic [NREQ-1:0] done;
        logic            irq;
        logic            uflow;
    } regs_t;

    regs_t r_q, r_d;

    // Shared window arithmetic
    logic [2*AW-1:0] step_in, step_out;
    logic [AW-1:0]   shadow_nx, rptr_nx;
    logic [CW-1:0]   win_size, free_cnt;
    logic            win_ok, is_empty;

    assign step_in   = {r_q.rptr, r_q.shadow};
    assign shadow_nx = step_out[0 +: AW];
    assign rptr_nx   = step_out[AW +: AW];

    ipcq_window #(.AW(AW), .NSTEP(2)) u_window (
        .win_lo   (r_q.lo),
        .win_hi   (r_q.hi),
        .wr_ptr   (r_q.wptr),
        .rd_ptr   (r_q.rptr),
        .step_in  (step_in),
        .step_out (step_out),
        .win_size (win_size),
        .free_cnt (free_cnt),
        .win_ok   (win_ok),
        .is_empty (is_empty)
    );

    // Requester selection
    logic          arb_any;
    logic [IW-1:0] arb_pick;

    ipcq_rr_arb #(.NREQ(NREQ), .IW(IW)) u_arb (
        .req  (prod_req),
        .last (r_q.last),
        .any  (arb_any),
        .pick (arb_pick)
    );

    // Write port into shared storage
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [LEN_W-1:0] pick_len;

    assign pick_len  = prod_len[arb_pick*LEN_W +: LEN_W];
    assign mem_wdata = prod_wdata[r_q.owner*DW +: DW];
    assign mem_we    = (r_q.st == ARB_XFER) && prod_wvalid[r_q.owner] && !cfg_we;

    ipcq_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (r_q.shadow),
        .wdata (mem_wdata),
        .raddr (r_q.rptr),
        .rdata (cons_rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rej  = '0;
        r_d.done = '0;
        r_d.irq  = 1'b0;

        unique case (r_q.st)
            ARB_IDLE: begin
                if (arb_any) begin
                    if (win_ok && (pick_len != '0) &&
                        (free_cnt >= CW'(pick_len))) begin
                        r_d.st     = ARB_XFER;
                        r_d.owner  = arb_pick;
                        r_d.shadow = r_q.wptr;
                        r_d.cnt    = '0;
                        r_d.len    = pick_len;
                    end else begin
                        r_d.rej[arb_pick] = 1'b1;
                        r_d.last          = arb_pick;
                        r_d.st            = ARB_HOLD;
                    end
                end
            end
            ARB_XFER: begin
                if (prod_wvalid[r_q.owner]) begin
                    r_d.shadow = shadow_nx;
                    r_d.cnt    = r_q.cnt + LEN_W'(1);
                    if (r_q.cnt == r_q.len - LEN_W'(1)) begin
                        r_d.wptr            = shadow_nx;
                        r_d.irq             = 1'b1;
                        r_d.done[r_q.owner] = 1'b1;
                        r_d.last            = r_q.owner;
                        r_d.st              = ARB_HOLD;
                    end
                end
            end
            ARB_HOLD: r_d.st = ARB_IDLE;
            default:  r_d.st = ARB_IDLE;
        endcase

        if (cons_pop) begin
            if (!is_empty) begin
                r_d.rptr = rptr_nx;
            end else begin
                r_d.uflow = 1'b1;
            end
        end

        if (cfg_we) begin
            r_d.lo     = cfg_lo;
            r_d.hi     = cfg_hi;
            r_d.wptr   = cfg_lo;
            r_d.rptr   = cfg_lo;
            r_d.shadow = cfg_lo;
            r_d.uflow  = 1'b0;
            r_d.st     = ARB_IDLE;
            r_d.rej    = '0;
            r_d.done   = '0;
            r_d.irq    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ARB_IDLE;
            r_q.last   <= IW'(NREQ - 1);
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_gnt
        assign prod_gnt[g] = (r_q.st == ARB_XFER) && (r_q.owner == IW'(g));
    end

    assign prod_rej       = r_q.rej;
    assign prod_done      = r_q.done;
    assign irq_msg        = r_q.irq;
    assign cons_empty     = is_empty;
    assign cons_underflow = r_q.uflow;
    assign q_lo           = r_q.lo;
    assign q_hi           = r_q.hi;
    assign q_wptr         = r_q.wptr;
    assign q_rptr         = r_q.rptr;
    assign q_free         = free_cnt;
    assign q_ready        = win_ok;

endmodule

// File: rtl/ipcq_checker.sv
module ipcq_checker #(
    parameter int unsigned AW   = 6,
    parameter int unsigned NREQ = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [NREQ-1:0] prod_gnt,
    input logic [NREQ-1:0] prod_done,
    input logic            cons_pop,
    input logic            cons_empty,
    input logic            cons_underflow,
    input logic            irq_msg,
    input logic [AW-1:0]   q_lo,
    input logic [AW-1:0]   q_hi,
    input logic [AW-1:0]   q_wptr,
    input logic [AW-1:0]   q_rptr,
    input logic [AW:0]     q_free,
    input logic            q_ready
);
    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prod_gnt));

    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|prod_gnt) && !cfg_we) |=> ((prod_gnt == $past(prod_gnt)) || (|prod_done)));

    assert_wptr_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((q_wptr == $past(q_wptr)) || irq_msg));

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |=> !irq_msg);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg |-> !cons_empty);

    assert_free_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> (q_free <= {1'b0, q_hi - q_lo}));

    assert_ptr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> ((q_wptr >= q_lo) && (q_wptr <= q_hi) &&
                     (q_rptr >= q_lo) && (q_rptr <= q_hi)));

    assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_pop && cons_empty && !cfg_we) |=> cons_underflow);

    assert_rptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_pop && cons_empty && !cfg_we) |=> $stable(q_rptr));

    assert_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_ready |-> (prod_gnt == '0));

endmodule

bind ipc_ring_queue ipcq_checker #(.AW(AW), .NREQ(NREQ)) u_ipcq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .prod_gnt       (prod_gnt),
    .prod_done      (prod_done),
    .cons_pop       (cons_pop),
    .cons_empty     (cons_empty),
    .cons_underflow (cons_underflow),
    .irq_msg        (irq_msg),
    .q_lo           (q_lo),
    .q_hi           (q_hi),
    .q_wptr         (q_wptr),
    .q_rptr         (q_rptr),
    .q_free         (q_free),
    .q_ready        (q_ready)
);

// File: tb/test_ipc_ring_queue.sv
module test_ipc_ring_queue;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int DW   = 32;
    localparam int NREQ = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_lo = '0;
    logic [AW-1:0]     cfg_hi = '0;
    logic [NREQ-1:0]   prod_req = '0;
    logic [2*NREQ-1:0] prod_len = '0;
    logic [NREQ-1:0]   prod_wvalid = '0;
    logic [DW*NREQ-1:0] prod_wdata = '0;
    logic [NREQ-1:0]   prod_gnt, prod_rej, prod_done;
    logic              cons_pop = 1'b0;
    logic [DW-1:0]     cons_rdata;
    logic              cons_empty, cons_underflow, irq_msg, q_ready;
    logic [AW-1:0]     q_lo, q_hi, q_wptr, q_rptr;
    logic [AW:0]       q_free;

    ipc_ring_queue #(.AW(AW), .DW(DW), .NREQ(NREQ)) i_ipc_ring_queue (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .prod_req(prod_req), .prod_len(prod_len), .prod_wvalid(prod_wvalid),
        .prod_wdata(prod_wdata), .prod_gnt(prod_gnt), .prod_rej(prod_rej),
        .prod_done(prod_done), .cons_pop(cons_pop), .cons_rdata(cons_rdata),
        .cons_empty(cons_empty), .cons_underflow(cons_underflow), .irq_msg(irq_msg),
        .q_lo(q_lo), .q_hi(q_hi), .q_wptr(q_wptr), .q_rptr(q_rptr),
        .q_free(q_free), .q_ready(q_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    int          m_lo = 0, m_hi = 0, m_w = 0, m_r = 0;
    bit          m_uf = 0, m_irq = 0, mon_on = 0;
    logic [DW-1:0] m_mem [int];
    int          n_vec = 0, n_bad = 0;
    int          grant_log [$];

    function automatic int m_size();  return m_hi - m_lo + 1; endfunction
    function automatic bit m_ready(); return (m_hi >= m_lo) && (m_size() >= 3); endfunction
    function automatic int m_free();
        if (!m_ready()) return 0;
        if (m_r > m_w) return m_r - m_w - 1;
        return m_size() - (m_w - m_r) - 1;
    endfunction
    function automatic int m_step(int p); return (p == m_hi) ? m_lo : p + 1; endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            chk(int'(q_wptr) == m_w, "R5 wptr", q_wptr, m_w);
            chk(int'(q_rptr) == m_r, "R7 rptr", q_rptr, m_r);
            chk(cons_empty == (m_w == m_r), "R9 empty", cons_empty, (m_w == m_r));
            chk(int'(q_free) == m_free(), "R3 free", q_free, m_free());
            chk(q_ready == m_ready(), "R2 ready", q_ready, m_ready());
            chk(cons_underflow == m_uf, "R8 underflow", cons_underflow, m_uf);
            chk(irq_msg == m_irq, "R5 irq", irq_msg, m_irq);
            if (m_w != m_r)
                chk(cons_rdata == m_mem[m_r], "R7 rdata", cons_rdata, m_mem[m_r]);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic cfg(int lo, int hi);
        cfg_we = 1'b1; cfg_lo = AW'(lo); cfg_hi = AW'(hi);
        tick();
        cfg_we = 1'b0;
        m_lo = lo; m_hi = hi; m_w = lo; m_r = lo; m_uf = 0;
    endtask

    task automatic pop1();
        cons_pop = 1'b1;
        tick();
        cons_pop = 1'b0;
        if (m_w == m_r) m_uf = 1; else m_r = m_step(m_r);
    endtask

    task automatic push(int who, int len, logic [DW-1:0] base, int stall, output bit acc);
        bit exp_ok;
        int addr;
        acc = 0;
        prod_req[who] = 1'b1;
        prod_len[who*2 +: 2] = 2'(len);
        for (int t = 0; t < 60; t++) begin
            tick();
            if (prod_gnt[who] || prod_rej[who]) break;
        end
        exp_ok = m_ready() && (len >= 1) && (len <= 3) && (m_free() >= len);
        if (prod_rej[who]) begin
            chk(!exp_ok, "R3/R10 reject decision", 0, exp_ok);
            prod_req[who] = 1'b0;
            return;
        end
        chk(exp_ok && prod_gnt[who], "R3 grant decision", prod_gnt[who], exp_ok);
        grant_log.push_back(who);
        addr = m_w;
        for (int k = 0; k < len; k++) begin
            for (int s = 0; s < stall; s++) begin
                prod_wvalid[who] = 1'b0;
                tick();
                chk(prod_gnt[who], "R6 grant held", prod_gnt[who], 1);
            end
            prod_wvalid[who] = 1'b1;
            prod_wdata[who*DW +: DW] = base + DW'(k);
            tick();
            m_mem[addr] = base + DW'(k);
            addr = m_step(addr);
        end
        prod_wvalid[who] = 1'b0;
        chk(prod_done[who], "R5 done pulse", prod_done[who], 1);
        prod_req[who] = 1'b0;
        m_w = addr;
        m_irq = 1;
        acc = 1;
        tick();
        m_irq = 0;
    endtask

    bit ok0, ok1;

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        // R1 reset state
        chk(cons_empty && !q_ready && prod_gnt == 0 && prod_rej == 0 && prod_done == 0,
            "R1 reset flags", {cons_empty, q_ready, prod_gnt}, 4'b1000);
        chk(!irq_msg && !cons_underflow && q_wptr == 0 && q_rptr == 0 && q_lo == 0 && q_hi == 0,
            "R1 reset regs", {irq_msg, cons_underflow, q_wptr}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1;

        // R10: nothing accepted before a valid window
        push(0, 1, 32'hA000, 0, ok0);
        chk(!ok0, "R10 reject unconfigured", ok0, 0);
        // R8: pop on empty
        pop1();
        chk(cons_underflow, "R8 underflow set", cons_underflow, 1);

        // R2: window 4..9 (6 words)
        cfg(4, 9);
        chk(q_rptr == 4 && q_wptr == 4 && q_ready, "R2 cfg load", q_rptr, 4);
        chk(!cons_underflow, "R2 underflow cleared", cons_underflow, 0);

        push(0, 3, 32'h1000, 0, ok0);
        chk(ok0, "R5 first message", ok0, 1);
        push(1, 3, 32'h2000, 0, ok1);          // free 2 < 3
        chk(!ok1, "R3 reject no room", ok1, 0);
        push(1, 2, 32'h3000, 1, ok1);          // exactly fills to one spare
        chk(ok1 && q_free == 0, "R3 fill to limit", q_free, 0);
        push(0, 1, 32'h4000, 0, ok0);
        chk(!ok0, "R3 reject when full", ok0, 0);

        // R7 peek then pop
        repeat (2) tick();
        chk(cons_rdata == 32'h1000 && q_rptr == 4, "R7 peek not consumed", cons_rdata, 32'h1000);
        pop1();
        pop1();
        chk(cons_rdata == 32'h1002, "R7 pop order", cons_rdata, 32'h1002);

        // R4 wrap: w=9 -> writes 9, 4 -> w=5
        push(0, 2, 32'h5000, 2, ok0);
        chk(ok0 && q_wptr == 5, "R4 write wrap", q_wptr, 5);
        for (int i = 0; i < 6; i++) pop1();
        chk(q_rptr == 5 && cons_empty, "R4 read wrap", q_rptr, 5);
        pop1();
        chk(cons_underflow && q_rptr == 5, "R8 pop ignored", q_rptr, 5);

        // R3 zero length
        push(1, 0, 32'h6000, 0, ok1);
        chk(!ok1, "R3 zero length rejected", ok1, 0);

        // R6 round robin
        cfg(0, 15);
        grant_log.delete();
        push(0, 1, 32'h7000, 0, ok0);
        fork
            push(0, 2, 32'h7100, 0, ok0);
            push(1, 3, 32'h7200, 1, ok1);
        join
        chk(grant_log.size() == 3 && grant_log[1] == 1 && grant_log[2] == 0,
            "R6 rotation order", grant_log.size() > 1 ? grant_log[1] : -1, 1);
        for (int i = 0; i < 6; i++) pop1();
        chk(cons_empty, "R9 drained", cons_empty, 1);

        // R2 invalid windows
        cfg(10, 8);
        chk(!q_ready, "R2 lo above hi", q_ready, 0);
        push(0, 1, 32'h8000, 0, ok0);
        chk(!ok0, "R10 reject bad window", ok0, 0);
        cfg(20, 21);
        chk(!q_ready, "R2 window too small", q_ready, 0);
        cfg(20, 22);
        chk(q_ready && q_free == 2, "R2 minimum window", q_free, 2);

        repeat (3) tick();
        mon_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule